// File: doc/BRIEF.md
# Single-carrier three-level PWM gate generator

This block drives the twelve switch gates of a three-phase, three-level clamped inverter bridge. Each leg receives an upper and a lower duty word. Both words of every leg are compared against one shared symmetric triangular carrier. The two comparison results select one of the three leg levels: high, mid or low. Each level closes exactly two of the leg's four series switches. A dead-time cell then delays every turn-on edge, so that complementary switches never conduct together.

The carrier is an up/down counter that runs between zero and a programmable top value. Duty words are sampled only at the carrier extremes. A strobe marks those extremes, so a controller upstream can time its updates to them. The duty words must be computed elsewhere. They share the carrier's scale: a word of 0 never wins a comparison, and a word above the top value always wins.

Top module: `tlp_gate_gen`

## Requirements
- R1: The carrier starts at 0 after reset and steps by one each clock, from 0 up to the top value and back down to 0. A full cycle therefore takes 2·TOP clocks. The top value is taken from `period_i` only in a cycle where the carrier is 0.
- R2: `peak_o` is 1 exactly in the cycles where the carrier is 0, or where it is rising and has reached the top value.
- R3: Duty words are captured only in a cycle where `peak_o` is 1, and they are used from the next cycle. A change on a duty input at any other time has no effect on the gates until the next extreme.
- R4: Per leg, define hi = (upper duty > carrier) and lo = (lower duty > carrier). The commanded level is high when hi and lo are both 1, low when both are 0, and mid when only lo is 1. The gate bit order is `gate_o[k][0]`=switch 1 (outer top), [1]=switch 2, [2]=switch 3, [3]=switch 4 (outer bottom). High = 4'b0011, mid = 4'b0110, low = 4'b1100.
- R5: When hi is 1 and lo is 0, the leg is forced to mid (4'b0110). Switch 1 and switch 4 are never on together.
- R6: Switch 3 is requested exactly when switch 1 is not, and switch 4 exactly when switch 2 is not. No more than two gates of a leg are ever on, and the pairs 1/3, 2/4 and 1/4 are never on together.
- R7: A gate turns on `dead_i`+1 clocks after its request rises, provided the request stays high. It turns off one clock after its request falls. Between the fall of one gate of a complementary pair and the rise of the other, both gates are off for exactly `dead_i` clocks.
- R8: While `rst_n` is 0, all gates are 0, the carrier is 0, `peak_o` is 1 and the captured duties are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | DW (10) | Carrier top value, sampled at the carrier bottom |
| dead_i | input | TW (6) | Turn-on delay in clocks |
| duty_up_i | input | LEGS x DW (3x10) | Upper duty word per leg |
| duty_lo_i | input | LEGS x DW (3x10) | Lower duty word per leg |
| gate_o | output | LEGS x 4 (3x4) | Gate lines, bit 0 = switch 1 ... bit 3 = switch 4 |
| peak_o | output | 1 | High in carrier top and bottom cycles |

## Verification
Two things can fall in the same cycle: the capture of a new duty pair at a carrier extreme, and a dead-time countdown that is still running from the previous level change. The bottom extreme also reloads the top value at the same moment. Random duty changes are applied on every slope, and the top value and the dead time are changed now and then. This makes level changes land right at the extremes, while delays of up to five clocks are still counting. A bench model, rebuilt from the requirements, predicts every gate and strobe cycle by cycle. Directed cases separately judge the hold-off between extremes and the exact mid-state gap width.

// File: rtl/tlp_pkg.sv
// Shared types for the three-level PWM gate generator.
// Assumes gate bit order switch1..switch4 = bit0..bit3.
package tlp_pkg;

    localparam int SW_PER_LEG = 4;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    // Map a leg level to its four switch requests (bit0 = switch 1).
    function automatic logic [SW_PER_LEG-1:0] lvl_to_sw(input lvl_e lvl);
        case (lvl)
            LVL_HIGH: lvl_to_sw = 4'b0011;
            LVL_MID:  lvl_to_sw = 4'b0110;
            default:  lvl_to_sw = 4'b1100;
        endcase
    endfunction

endpackage

// File: rtl/tlp_carrier.sv
// Symmetric triangular carrier: counts 0 -> top -> 0.
// The top value is reloaded only when the count is 0. peak_o marks
// both extremes. A top value of 0 holds the carrier at 0.
module tlp_carrier #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic          peak_o
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_q;
    logic          up_q;
    logic          at_bot;
    logic          at_top;
    logic [CW-1:0] per_use;

    // Extreme detection and effective top value for this cycle.
    always_comb begin
        at_bot  = (cnt_q == ZERO);
        at_top  = up_q && (cnt_q >= per_q);
        per_use = at_bot ? period_i : per_q;
    end

    // Up/down count with direction reversal at the extremes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            per_q <= ZERO;
            up_q  <= 1'b0;
        end else begin
            if (at_bot) per_q <= period_i;
            if (up_q) begin
                if (cnt_q < per_use) begin
                    cnt_q <= cnt_q + ONE;
                end else begin
                    up_q <= 1'b0;
                    if (cnt_q != ZERO) cnt_q <= cnt_q - ONE;
                end
            end else begin
                if (cnt_q != ZERO) begin
                    cnt_q <= cnt_q - ONE;
                end else begin
                    up_q <= 1'b1;
                    if (per_use != ZERO) cnt_q <= ONE;
                end
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign peak_o = at_bot || at_top;

    // R1: the carrier never exceeds the active top value.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q);

    // R1: away from the extremes the carrier moves by exactly one.
    p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_bot && !at_top) |=>
        ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

endmodule

// File: rtl/tlp_deadtime.sv
// Turn-on delay cell: the output rises dead_i+1 clocks after the
// request rises, and falls one clock after the request falls.
// Assumes dead_i is stable while a delay is counting.
module tlp_deadtime #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] dead_i,
    input  logic          req_i,
    output logic          out_o
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] wait_q;

    // Count the request's on-time, then release the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            out_o  <= 1'b0;
        end else if (!req_i) begin
            wait_q <= '0;
            out_o  <= 1'b0;
        end else if (wait_q >= dead_i) begin
            out_o  <= 1'b1;
        end else begin
            wait_q <= wait_q + ONE;
        end
    end

    // R7: a gate only turns on while it is requested.
    p_on_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_o) |-> $past(req_i));

    // R7: a dropped request clears the gate on the next clock.
    p_fast_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !out_o);

endmodule

// File: rtl/tlp_leg.sv
// One inverter leg: captures its duty pair at carrier extremes, compares
// both words with the shared carrier, decodes the level and drives four
// dead-time cells. An upper-only win is forced to the mid level.
module tlp_leg
    import tlp_pkg::*;
#(
    parameter int DW = 10,
    parameter int TW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         cnt_i,
    input  logic                  peak_i,
    input  logic [TW-1:0]         dead_i,
    input  logic [DW-1:0]         duty_up_i,
    input  logic [DW-1:0]         duty_lo_i,
    output logic [SW_PER_LEG-1:0] gate_o
);
    logic [DW-1:0]         dup_q;
    logic [DW-1:0]         dlo_q;
    logic                  hi_win;
    logic                  lo_win;
    lvl_e                  lvl;
    logic [SW_PER_LEG-1:0] sw_req;

    // Duty double buffer: take new words only at a carrier extreme.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_q <= '0;
            dlo_q <= '0;
        end else if (peak_i) begin
            dup_q <= duty_up_i;
            dlo_q <= duty_lo_i;
        end
    end

    // Compare both words with the single carrier and pick a level.
    always_comb begin
        hi_win = (dup_q > cnt_i);
        lo_win = (dlo_q > cnt_i);
        if (hi_win && lo_win)      lvl = LVL_HIGH;
        else if (hi_win || lo_win) lvl = LVL_MID;
        else                       lvl = LVL_LOW;
        sw_req = lvl_to_sw(lvl);
    end

    // One turn-on delay cell per switch.
    for (genvar s = 0; s < SW_PER_LEG; s++) begin : g_dt
        tlp_deadtime #(.TW(TW)) dt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .dead_i (dead_i),
            .req_i  (sw_req[s]),
            .out_o  (gate_o[s])
        );
    end

    // R3: captured duties hold between carrier extremes.
    p_duty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_i |=> ($stable(dup_q) && $stable(dlo_q)));

    // R6: never more than two switches of the leg closed.
    p_two_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_o) <= 2);

    // R6: complementary pairs never overlap.
    p_pair13_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[2]));
    p_pair24_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[1] && gate_o[3]));

    // R5: outer switches never on together.
    p_outer_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[3]));

endmodule

// File: rtl/tlp_gate_gen.sv
// Top: one shared triangular carrier feeding LEGS leg slices.
// Assumes duty words use the carrier scale (a word above the top value
// always wins its comparison).
module tlp_gate_gen #(
    parameter int LEGS = 3,
    parameter int DW   = 10,
    parameter int TW   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DW-1:0]              period_i,
    input  logic [TW-1:0]              dead_i,
    input  logic [LEGS-1:0][DW-1:0]    duty_up_i,
    input  logic [LEGS-1:0][DW-1:0]    duty_lo_i,
    output logic [LEGS-1:0][3:0]       gate_o,
    output logic                       peak_o
);
    logic [DW-1:0] cnt;
    logic          peak;

    tlp_carrier #(.CW(DW)) carrier_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .cnt_o    (cnt),
        .peak_o   (peak)
    );

    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        tlp_leg #(.DW(DW), .TW(TW)) leg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_i     (cnt),
            .peak_i    (peak),
            .dead_i    (dead_i),
            .duty_up_i (duty_up_i[k]),
            .duty_lo_i (duty_lo_i[k]),
            .gate_o    (gate_o[k])
        );
    end

    assign peak_o = peak;

endmodule

// File: tb/tlp_gate_gen_tb_top.sv
module tlp_gate_gen_tb_top;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [9:0]      period = 10'd8;
    logic [5:0]      dead = 6'd0;
    logic [2:0][9:0] du = '0;
    logic [2:0][9:0] dl = '0;
    logic [2:0][3:0] g;
    logic            peak;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tlp_gate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .period_i(period), .dead_i(dead),
        .duty_up_i(du), .duty_lo_i(dl), .gate_o(g), .peak_o(peak)
    );

    // ---------------- reference model built from the requirements ----
    int       m_c, m_top;
    bit       m_rise;
    int       m_u[3], m_l[3];
    int       m_wait[3][4];
    bit [3:0] m_g[3];

    function automatic bit m_extreme();
        return (m_c == 0) || (m_rise && m_c >= m_top);
    endfunction

    // R4/R5 formulation: s2 if either wins, s1 only if both, s4 if none.
    function automatic bit [3:0] want_sw(int up, int lo, int c);
        bit h, l;
        bit [3:0] r;
        h = up > c;
        l = lo > c;
        r[0] = h && l;
        r[1] = h || l;
        r[2] = !(h && l);
        r[3] = !(h || l);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c = 0; m_top = 0; m_rise = 0;
            for (int k = 0; k < 3; k++) begin
                m_u[k] = 0; m_l[k] = 0; m_g[k] = 4'b0;
                for (int s = 0; s < 4; s++) m_wait[k][s] = 0;
            end
        end else begin
            bit ext;
            int top_now;
            ext = m_extreme();
            top_now = (m_c == 0) ? int'(period) : m_top;
            for (int k = 0; k < 3; k++) begin
                bit [3:0] rq;
                rq = want_sw(m_u[k], m_l[k], m_c);
                for (int s = 0; s < 4; s++) begin
                    if (!rq[s]) begin
                        m_wait[k][s] = 0; m_g[k][s] = 0;
                    end else if (m_wait[k][s] >= int'(dead)) begin
                        m_g[k][s] = 1;
                    end else begin
                        m_wait[k][s]++;
                    end
                end
            end
            if (ext) begin
                for (int k = 0; k < 3; k++) begin
                    m_u[k] = int'(du[k]); m_l[k] = int'(dl[k]);
                end
            end
            if (m_c == 0) m_top = int'(period);
            if (m_rise) begin
                if (m_c < top_now) m_c++;
                else begin m_rise = 0; if (m_c > 0) m_c--; end
            end else begin
                if (m_c > 0) m_c--;
                else begin m_rise = 1; if (top_now > 0) m_c = 1; end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (peak !== m_extreme()) begin
                n_errors++;
                $display("FAIL R2 peak: got %0b expected %0b", peak, m_extreme());
            end
            for (int k = 0; k < 3; k++) begin
                n_checks++;
                if (g[k] !== m_g[k]) begin
                    n_errors++;
                    $display("FAIL R4 leg %0d gates: got %b expected %b", k, g[k], m_g[k]);
                end
                n_checks++;
                if ($countones(g[k]) > 2 || (g[k][0] && g[k][3])) begin
                    n_errors++;
                    $display("FAIL R6 leg %0d gates: got %b expected at most two, no 1+4", k, g[k]);
                end
            end
        end
    end

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic finish_sim();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_sim();
    end

    initial begin
        int k_cnt;
        void'($urandom(32'd4242));
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 gates in reset", int'(g), 0);
        check("R8 peak in reset", int'(peak), 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R1: spacing of extremes is the top value
        for (int i = 0; i < 2; i++) begin
            while (!peak) @(negedge clk);
            k_cnt = 0;
            do begin @(negedge clk); k_cnt++; end while (!peak);
            check("R1 half-cycle length", k_cnt, 8);
        end

        // R4/R5: steady levels
        dead = 6'd2;
        du[0] = 10'd0; dl[0] = 10'd0;
        du[1] = 10'd9; dl[1] = 10'd0;
        du[2] = 10'd9; dl[2] = 10'd9;
        repeat (40) @(negedge clk);
        check("R4 low level", int'(g[0]), 4'b1100);
        check("R5 forced mid", int'(g[1]), 4'b0110);
        check("R4 high level", int'(g[2]), 4'b0011);

        // R3: change between extremes has no effect until next extreme
        while (!peak) @(negedge clk);
        repeat (2) @(negedge clk);
        du[2] = 10'd0; dl[2] = 10'd0;
        repeat (2) begin
            @(negedge clk);
            check("R3 hold before extreme", int'(g[2]), 4'b0011);
        end
        repeat (14) @(negedge clk);
        check("R3 applied after extreme", int'(g[2]), 4'b1100);

        // R7: gap between switch 4 off and switch 2 on equals dead time
        dl[0] = 10'd9;
        k_cnt = 0;
        while (g[0][3] && k_cnt < 40) begin @(negedge clk); k_cnt++; end
        k_cnt = 0;
        while (!g[0][1] && k_cnt < 40) begin @(negedge clk); k_cnt++; end
        check("R7 dead gap", k_cnt, 2);

        // Random phase with corner values
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom % 8 == 0) begin
                int k, sel;
                k = $urandom % 3;
                sel = $urandom % 5;
                case (sel)
                    0: begin du[k] = 0; dl[k] = 0; end
                    1: begin du[k] = 10'(period + 1); dl[k] = 10'(period + 1); end
                    2: begin du[k] = 10'(period); dl[k] = 0; end
                    default: begin
                        du[k] = 10'($urandom % (period + 2));
                        dl[k] = 10'($urandom % (period + 2));
                    end
                endcase
            end
            if ($urandom % 500 == 0) period = 10'(4 + $urandom % 30);
            if ($urandom % 300 == 0) dead = 6'($urandom % 6);
        end
        repeat (4) @(negedge clk);
        finish_sim();
    end
endmodule